// File: doc/BRIEF.md
# Encoder Input Conditioning and Timer Routing

This block prepares the four signals of an incremental shaft encoder (phase A, phase B, index and home) for the rest of a motion-control subsystem. Each pin is first brought into the clock domain by a two-stage synchronizer. It is then cleaned by a digital glitch filter that samples once every N clock cycles. A new level is accepted only after three samples in a row agree. Setting N to zero bypasses the filter. The filtered signals feed a downstream quadrature decoder core. Both the raw and the filtered levels are also presented as 3-bit status words.

A routing matrix drives the four input channels of a companion general-purpose timer. A 2-bit mode selects what reaches them. One mode passes the pins straight through and another passes the filtered signals. A third mode copies filtered phase A onto two channels and filtered phase B onto the other two, so the timer can capture both edges of each phase and measure edge-to-edge periods at very low speed. The block has no data stream. All pins are plain levels, and no valid/ready handshake or back-pressure applies.

Top module: `enc_filter_route`

## Requirements
- R1: Each pin reaches the raw status word `raw_word_o` exactly two clock edges after it is sampled. The word holds index in bit 0, phase B in bit 1 and phase A in bit 2.
- R2: When `filt_interval_i` = N > 0, the filter samples the synchronized inputs on every Nth clock edge. A filtered output takes a new level only on a sample edge where the current sample and the two samples before it all equal that level.
- R3: A pulse on a pin that is shorter than three consecutive sample points never appears on the filtered outputs.
- R4: When `filt_interval_i` is 0 the filter is bypassed, and each filtered output equals the synchronized input in the same cycle.
- R5: In route mode 0, timer channels 0, 1, 2 and 3 carry the unsynchronized pins phase A, phase B, index and home, with no clock delay.
- R6: In route mode 1, timer channels 0 to 3 carry filtered phase A, phase B, index and home, in that order.
- R7: In route mode 2, timer channels 0 and 1 carry filtered phase A, and channels 2 and 3 carry filtered phase B.
- R8: Route mode 3 is reserved and behaves exactly like mode 0.
- R9: The decoder-core outputs carry the filtered signals. The filtered status word `filt_word_o` uses the same bit layout as R1.
- R10: While `rst_n` is low, all synchronizer stages, filter histories and filter outputs are cleared. With the pins held low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_a_i | input | 1 | Encoder phase A pin |
| enc_b_i | input | 1 | Encoder phase B pin |
| enc_idx_i | input | 1 | Encoder index pin |
| enc_home_i | input | 1 | Home switch pin |
| filt_interval_i | input | FILT_W (8) | Filter sample interval in clocks; 0 bypasses the filter |
| route_mode_i | input | 2 | Timer routing mode (0 raw, 1 filtered, 2 split phases, 3 as 0) |
| core_a_o | output | 1 | Filtered phase A to decoder core |
| core_b_o | output | 1 | Filtered phase B to decoder core |
| core_idx_o | output | 1 | Filtered index to decoder core |
| core_home_o | output | 1 | Filtered home to decoder core |
| tmr_ch_o | output | 4 | Timer channel inputs, bit n = channel n |
| raw_word_o | output | 3 | Synchronized raw levels {A, B, index} |
| filt_word_o | output | 3 | Filtered levels {A, B, index} |

## Verification
The checker tests several properties on every cycle: the two-edge latency of the raw word, the equality of the filtered and synchronized words in bypass, the fact that a filtered bit can only change to the level just sampled, and the channel patterns of modes 1 and 2. Some behaviour depends on history and timing, so only the bench's scenarios can show it. That includes the exact sample-edge spacing for each interval, the three-sample agreement rule, the rejection of short glitches, the reserved mode 3 and the reset state. The bench's cycle-accurate reference model covers these.

// File: rtl/enc_fr_pkg.sv
package enc_fr_pkg;
  localparam int NSIG = 4;

  typedef enum logic [1:0] {
    RT_RAW   = 2'd0,
    RT_FILT  = 2'd1,
    RT_SPLIT = 2'd2,
    RT_RSVD  = 2'd3
  } route_e;

  // bit 0 = phase A, bit 1 = phase B, bit 2 = index, bit 3 = home
  typedef struct packed {
    logic home;
    logic idx;
    logic b;
    logic a;
  } enc_sig_t;

  function automatic logic [2:0] status_word(enc_sig_t s);
    return {s.a, s.b, s.idx};
  endfunction
endpackage

// File: rtl/enc_sync.sv
module enc_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/enc_tick.sv
module enc_tick #(
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] interval,
  output logic          bypass,
  output logic          tick
);
  logic [IW-1:0] cnt_q;
  logic [IW-1:0] last_cnt;

  assign bypass   = (interval == '0);
  assign last_cnt = interval - 1'b1;
  assign tick     = !bypass && (cnt_q >= last_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (bypass) cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/enc_glitch.sv
module enc_glitch #(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  input  logic tick,
  input  logic bypass,
  output logic y
);
  logic [DEPTH-1:0] hist_q;
  logic [DEPTH-1:0] hist_nx;
  logic             q_r;
  logic             agree;

  assign hist_nx = {hist_q[DEPTH-2:0], d};
  assign agree   = (&hist_nx) | ~(|hist_nx);
  assign y       = bypass ? d : q_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q <= '0;
      q_r    <= 1'b0;
    end else if (bypass) begin
      hist_q <= {DEPTH{d}};
      q_r    <= d;
    end else if (tick) begin
      hist_q <= hist_nx;
      if (agree) q_r <= d;
    end
  end
endmodule

// File: rtl/enc_route.sv
module enc_route
  import enc_fr_pkg::*;
(
  input  logic [1:0] mode,
  input  enc_sig_t   pins,
  input  enc_sig_t   filt,
  output logic [NSIG-1:0] ch
);
  always_comb begin
    unique case (route_e'(mode))
      RT_FILT:  ch = filt;
      RT_SPLIT: ch = {filt.b, filt.b, filt.a, filt.a};
      default:  ch = pins;
    endcase
  end
endmodule

// File: rtl/enc_filter_route.sv
module enc_filter_route
  import enc_fr_pkg::*;
#(
  parameter int FILT_W     = 8,
  parameter int FILT_DEPTH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_a_i,
  input  logic              enc_b_i,
  input  logic              enc_idx_i,
  input  logic              enc_home_i,
  input  logic [FILT_W-1:0] filt_interval_i,
  input  logic [1:0]        route_mode_i,
  output logic              core_a_o,
  output logic              core_b_o,
  output logic              core_idx_o,
  output logic              core_home_o,
  output logic [3:0]        tmr_ch_o,
  output logic [2:0]        raw_word_o,
  output logic [2:0]        filt_word_o
);
  enc_sig_t pin_v;
  enc_sig_t sync_v;
  enc_sig_t filt_v;
  logic     samp_tick;
  logic     bypass;

  assign pin_v = '{home: enc_home_i, idx: enc_idx_i, b: enc_b_i, a: enc_a_i};

  enc_sync #(.W(NSIG)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pin_v),
    .q    (sync_v)
  );

  enc_tick #(.IW(FILT_W)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .interval(filt_interval_i),
    .bypass  (bypass),
    .tick    (samp_tick)
  );

  for (genvar i = 0; i < NSIG; i++) begin : g_filt
    enc_glitch #(.DEPTH(FILT_DEPTH)) u_glitch (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (sync_v[i]),
      .tick  (samp_tick),
      .bypass(bypass),
      .y     (filt_v[i])
    );
  end

  enc_route u_route (
    .mode(route_mode_i),
    .pins(pin_v),
    .filt(filt_v),
    .ch  (tmr_ch_o)
  );

  assign core_a_o    = filt_v.a;
  assign core_b_o    = filt_v.b;
  assign core_idx_o  = filt_v.idx;
  assign core_home_o = filt_v.home;
  assign raw_word_o  = status_word(sync_v);
  assign filt_word_o = status_word(filt_v);
endmodule

// File: rtl/enc_fr_chk.sv
module enc_fr_chk #(
  parameter int FILT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enc_a_i,
  input logic              enc_b_i,
  input logic              enc_idx_i,
  input logic [FILT_W-1:0] filt_interval_i,
  input logic [1:0]        route_mode_i,
  input logic              core_a_o,
  input logic              core_b_o,
  input logic              core_idx_o,
  input logic              core_home_o,
  input logic [3:0]        tmr_ch_o,
  input logic [2:0]        raw_word_o,
  input logic [2:0]        filt_word_o
);
  logic [1:0] settle_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                settle_q <= '0;
    else if (settle_q != 2'd3) settle_q <= settle_q + 2'd1;
  end

  a_r1_sync_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (settle_q >= 2'd2) |->
      raw_word_o == {$past(enc_a_i, 2), $past(enc_b_i, 2), $past(enc_idx_i, 2)});

  a_r2_change_to_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (settle_q >= 2'd1 && filt_interval_i != '0 && $past(filt_interval_i) != '0) |->
      (((filt_word_o ^ $past(filt_word_o)) & (filt_word_o ^ $past(raw_word_o))) == 3'b000));

  a_r4_bypass_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_interval_i == '0) |-> (filt_word_o == raw_word_o));

  a_r6_mode1_filtered: assert property (@(posedge clk) disable iff (!rst_n)
    (route_mode_i == 2'd1) |->
      (tmr_ch_o == {core_home_o, core_idx_o, core_b_o, core_a_o}));

  a_r7_split_phases: assert property (@(posedge clk) disable iff (!rst_n)
    (route_mode_i == 2'd2) |->
      (tmr_ch_o == {filt_word_o[1], filt_word_o[1], filt_word_o[2], filt_word_o[2]}));

  a_r9_core_word: assert property (@(posedge clk) disable iff (!rst_n)
    filt_word_o == {core_a_o, core_b_o, core_idx_o});
endmodule

bind enc_filter_route enc_fr_chk #(.FILT_W(FILT_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .enc_a_i        (enc_a_i),
  .enc_b_i        (enc_b_i),
  .enc_idx_i      (enc_idx_i),
  .filt_interval_i(filt_interval_i),
  .route_mode_i   (route_mode_i),
  .core_a_o       (core_a_o),
  .core_b_o       (core_b_o),
  .core_idx_o     (core_idx_o),
  .core_home_o    (core_home_o),
  .tmr_ch_o       (tmr_ch_o),
  .raw_word_o     (raw_word_o),
  .filt_word_o    (filt_word_o)
);

// File: tb/enc_filter_route_tb.sv
module enc_filter_route_tb_top;
  localparam int FW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    pins = 4'h0;   // bit0 A, bit1 B, bit2 index, bit3 home
  logic [FW-1:0] iv = '0;
  logic [1:0]    mode = 2'd0;
  logic          core_a, core_b, core_idx, core_home;
  logic [3:0]    tmr;
  logic [2:0]    raw_w, filt_w;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  enc_filter_route #(.FILT_W(FW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .enc_a_i(pins[0]), .enc_b_i(pins[1]), .enc_idx_i(pins[2]), .enc_home_i(pins[3]),
    .filt_interval_i(iv), .route_mode_i(mode),
    .core_a_o(core_a), .core_b_o(core_b), .core_idx_o(core_idx), .core_home_o(core_home),
    .tmr_ch_o(tmr), .raw_word_o(raw_w), .filt_word_o(filt_w)
  );

  // ---------------- behavioural reference model ----------------
  logic [3:0] m_pipe [$];      // synchronizer delay line, two entries
  int         m_cnt;
  int         m_run [4];
  logic       m_last [4];
  logic       m_out [4];

  function automatic logic [3:0] m_sync();
    return m_pipe[1];
  endfunction

  task automatic m_reset();
    m_pipe = '{4'h0, 4'h0};
    m_cnt = 0;
    for (int i = 0; i < 4; i++) begin
      m_run[i] = 3; m_last[i] = 1'b0; m_out[i] = 1'b0;
    end
  endtask

  initial m_reset();

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) m_reset();
    else begin
      logic [3:0] d;
      bit t;
      d = m_sync();
      t = (iv != 0) && (m_cnt >= int'(iv) - 1);
      for (int i = 0; i < 4; i++) begin
        if (iv == 0) begin
          m_out[i] = d[i]; m_last[i] = d[i]; m_run[i] = 3;
        end else if (t) begin
          if (d[i] == m_last[i]) m_run[i] = (m_run[i] < 3) ? m_run[i] + 1 : 3;
          else m_run[i] = 1;
          m_last[i] = d[i];
          if (m_run[i] >= 3) m_out[i] = d[i];
        end
      end
      if (iv == 0 || t) m_cnt = 0; else m_cnt++;
      void'(m_pipe.pop_back());
      m_pipe.push_front(pins);
    end
  end

  function automatic logic [3:0] exp_filt();
    logic [3:0] f;
    logic [3:0] s;
    s = m_sync();
    for (int i = 0; i < 4; i++) f[i] = (iv == 0) ? s[i] : m_out[i];
    return f;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s at cycle %0d: actual=%h expected=%h", req, cyc, act, exp);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [3:0] s, f, et;
      s = m_sync();
      f = exp_filt();
      chk("R1", {5'd0, raw_w}, {5'd0, s[0], s[1], s[2]});
      chk((iv == 0) ? "R4" : "R2", {5'd0, filt_w}, {5'd0, f[0], f[1], f[2]});
      chk("R9", {4'd0, core_home, core_idx, core_b, core_a}, {4'd0, f});
      case (mode)
        2'd1: et = f;
        2'd2: et = {f[1], f[1], f[0], f[0]};
        default: et = pins;
      endcase
      case (mode)
        2'd0: chk("R5", {4'd0, tmr}, {4'd0, et});
        2'd1: chk("R6", {4'd0, tmr}, {4'd0, et});
        2'd2: chk("R7", {4'd0, tmr}, {4'd0, et});
        default: chk("R8", {4'd0, tmr}, {4'd0, et});
      endcase
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic rand_run(int n, int hold);
    for (int k = 0; k < n; k++) begin
      if ((k % hold) == 0) pins = 4'($urandom_range(0, 15));
      step(1);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    void'($urandom(32'h5eed));
    rst_n = 1'b0;
    step(3);
    // R10: reset state
    @(negedge clk);
    chk("R10", {1'b0, tmr, raw_w}, 8'h00);
    chk("R10", {1'b0, core_home, core_idx, core_b, core_a, filt_w}, 8'h00);
    step(1);
    rst_n = 1'b1;
    step(2);

    // bypass, all modes
    iv = '0;
    for (int m = 0; m < 4; m++) begin
      mode = 2'(m);
      rand_run(40, 1);
    end

    // interval 1 and 3, slow and fast activity
    iv = 8'd1;
    for (int m = 0; m < 4; m++) begin
      mode = 2'(m);
      rand_run(60, 4);
      rand_run(30, 1);
    end
    iv = 8'd3;
    for (int m = 0; m < 4; m++) begin
      mode = 2'(m);
      rand_run(120, 12);
      rand_run(40, 2);
    end

    // R3: short glitch on phase A must not pass
    iv = 8'd2; mode = 2'd1; pins = 4'h0;
    step(30);
    pins = 4'h1;
    step(3);
    pins = 4'h0;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      chk("R3", {7'd0, core_a}, 8'h00);
      step(1);
    end
    // long level does pass (R2)
    pins = 4'h1;
    step(12);
    @(negedge clk);
    chk("R2", {7'd0, core_a}, 8'h01);
    step(1);

    // interval change on the fly, then back to bypass
    iv = 8'd5; mode = 2'd2;
    rand_run(200, 20);
    iv = 8'd0; mode = 2'd3;
    rand_run(50, 3);

    // reset mid-run
    rst_n = 1'b0; pins = 4'h0;
    step(2);
    @(negedge clk);
    chk("R10", {1'b0, tmr, raw_w}, 8'h00);
    step(1);
    rst_n = 1'b1;
    iv = 8'd4;
    rand_run(100, 16);

    done = 1'b1;
    summary();
  end

  initial begin
    wait (cyc > 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      done = 1'b1;
      summary();
    end
  end
endmodule